// File: doc/BRIEF.md
# Four-Channel Programmable Clock Divider Bank

This block derives four slower clocks from one fast reference clock. Each channel counts reference cycles and gives two outputs: a divided clock level and a one-cycle tick that marks the last reference cycle of every output period. The tick can drive clock-enable logic. The four 6-bit ratio codes and their load bits sit in one 32-bit control word. A second word holds a global release bit and one sticky error flag for each channel. Both words are reached through a small write/read port that runs in the reference clock domain.

Software changes a ratio in three steps. It writes the code with the load bit clear. It writes the same word again with the load bit set. Later it clears the load bit. The channel looks for the rising edge of its load bit. A rising edge that arrives while the release bit is low is ignored. Channel 0 maps its code to a ratio through a fixed table that is not monotonic. Channels 1 to 3 use the code itself as the ratio. A new ratio waits until the current output period has ended, so the output never shows a shortened period. Rate rounding is left to software.

Top module: `divbank_top`

## Requirements
- R1: Word 0 (regSel=0) holds channel k's code in bits [1+7k+5 : 1+7k] and its load bit at bit 1+7k+6, for k = 0..3. Reading word 0 returns the last value written. Word 1 (regSel=1) holds the release bit at bit 10 and reads back the error flag of channel k at bit k. All other bits of word 1 read as 0.
- R2: After reset both words read 0, all error flags are clear, and every channel runs at ratio 4.
- R3: A code is captured only on a rising edge of its load bit while the release bit is 1. A load edge that arrives while the release bit is 0 has no effect, and setting the release bit afterwards does not apply it.
- R4: Channel 0 decodes codes 1..10 to ratios 2,1,3,4,6,5,7,8,10,9 in that order. Codes 0 and 11..63 are invalid.
- R5: On channels 1 to 3 the code is the ratio (1..63). Code 0 is invalid.
- R6: When an invalid code is captured, the channel keeps its current ratio and its error flag is set. The flag stays set until reset.
- R7: A captured ratio takes effect only at the end of the current output period. Every measured period equals either the old ratio or the new one.
- R8: divTick is high for exactly one reference cycle in every period of `ratio` cycles. divClk is high for floor(ratio/2) cycles at the start of the period and low for the rest of it.
- R9: At ratio 1, divClk equals the reference clock and divTick stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Word select: 0 = codes and load bits, 1 = release bit and error flags (byte offset 4) |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the selected word |
| divClk | output | 4 | Divided clock of each channel |
| divTick | output | 4 | One reference-cycle pulse at the end of each output period |

## Verification
The vector walk loads every channel-0 code into the table channel. Because the table swaps neighbouring ratios (1↔2, 5↔6, 9↔10), a design that used the code directly would show the wrong period. Channel 1 covers the extreme ratios 63 and 1, and channels 2 and 3 cover an even ratio and an odd ratio. Together these separate the high and low phase split of even and odd ratios from the period length. Invalid codes are followed by a period measurement and a read of the flags, which separates "ratio kept" from "ratio zeroed". A large ratio step (63 to 2) shows whether any shortened period appears. A load issued while the release bit is low, followed by setting the release bit, shows whether the design samples the load edge or the load level.

// File: rtl/divbank_pkg.sv
`timescale 1ns/1ps
package divbank_pkg;

  localparam int RATIO_W = 6;

  typedef struct packed {
    logic               load;
    logic [RATIO_W-1:0] ratio;
  } chanStrobe_t;

  // Returns {valid, ratio}. The table channel uses a non-monotonic code map.
  function automatic logic [RATIO_W:0] decodeCode(input logic useTable,
                                                   input logic [RATIO_W-1:0] code);
    logic [RATIO_W:0] res;
    res = '0;
    if (useTable) begin
      case (code)
        6'd1:    res = {1'b1, 6'd2};
        6'd2:    res = {1'b1, 6'd1};
        6'd3:    res = {1'b1, 6'd3};
        6'd4:    res = {1'b1, 6'd4};
        6'd5:    res = {1'b1, 6'd6};
        6'd6:    res = {1'b1, 6'd5};
        6'd7:    res = {1'b1, 6'd7};
        6'd8:    res = {1'b1, 6'd8};
        6'd9:    res = {1'b1, 6'd10};
        6'd10:   res = {1'b1, 6'd9};
        default: res = '0;
      endcase
    end else begin
      res = {(code != '0), code};
    end
    return res;
  endfunction

endpackage

// File: rtl/divbank_ctrl.sv
`timescale 1ns/1ps
module divbank_ctrl
  import divbank_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int DATA_W      = 32,
  parameter int RELEASE_BIT = 10,
  parameter int TABLE_CH    = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output chanStrobe_t       stb [NUM_CH]
);

  localparam int STRIDE = RATIO_W + 1;

  logic [DATA_W-1:0] ctrlWord;
  logic              releaseBit;
  logic [NUM_CH-1:0] loadPrev;
  logic [NUM_CH-1:0] loadNow;
  logic [NUM_CH-1:0] errFlags;
  logic [NUM_CH-1:0] errSet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlWord   <= '0;
      releaseBit <= 1'b0;
    end else if (wrEn) begin
      if (!regSel) ctrlWord   <= wrData;
      else         releaseBit <= wrData[RELEASE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadPrev <= '0;
      errFlags <= '0;
    end else begin
      loadPrev <= loadNow;
      errFlags <= errFlags | errSet;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    localparam int LSB = 1 + g * STRIDE;
    logic [RATIO_W-1:0] code;
    logic [RATIO_W:0]   dec;
    logic               rise;

    assign code       = ctrlWord[LSB +: RATIO_W];
    assign loadNow[g] = ctrlWord[LSB + RATIO_W];
    assign dec        = decodeCode(g == TABLE_CH, code);
    assign rise       = loadNow[g] & ~loadPrev[g] & releaseBit;
    assign errSet[g]  = rise & ~dec[RATIO_W];
    assign stb[g]     = '{load: rise & dec[RATIO_W], ratio: dec[RATIO_W-1:0]};

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      errFlags[g] |=> errFlags[g]); // R6
    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
      stb[g].load |=> !stb[g].load); // R3
  end

  always_comb begin
    rdData = '0;
    if (!regSel) begin
      rdData = ctrlWord;
    end else begin
      rdData[RELEASE_BIT]  = releaseBit;
      rdData[NUM_CH-1:0]   = errFlags;
    end
  end

endmodule

// File: rtl/divbank_chan.sv
`timescale 1ns/1ps
module divbank_chan
  import divbank_pkg::*;
#(
  parameter int DEFAULT_RATIO = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  chanStrobe_t stb,
  output logic        divClk,
  output logic        divTick
);

  localparam logic [RATIO_W-1:0] RST_RATIO = RATIO_W'(DEFAULT_RATIO);
  localparam logic               RST_PHASE = (DEFAULT_RATIO / 2) > 0;

  logic [RATIO_W-1:0] ratio;
  logic [RATIO_W-1:0] pendRatio;
  logic [RATIO_W-1:0] nextRatio;
  logic [RATIO_W-1:0] cnt;
  logic               pendValid;
  logic               phase;

  assign divTick = (cnt == ratio - 1'b1);

  always_comb begin
    if (stb.load)       nextRatio = stb.ratio;
    else if (pendValid) nextRatio = pendRatio;
    else                nextRatio = ratio;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ratio     <= RST_RATIO;
      pendRatio <= RST_RATIO;
      pendValid <= 1'b0;
      cnt       <= '0;
      phase     <= RST_PHASE;
    end else begin
      if (stb.load) begin
        pendRatio <= stb.ratio;
        pendValid <= 1'b1;
      end
      if (divTick) begin
        ratio     <= nextRatio;
        cnt       <= '0;
        phase     <= (nextRatio >> 1) != '0;
        pendValid <= 1'b0;
      end else begin
        cnt   <= cnt + 1'b1;
        phase <= (cnt + 1'b1) < (ratio >> 1);
      end
    end
  end

  assign divClk = (ratio == RATIO_W'(1)) ? clk : phase;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cnt < ratio); // R8
  AST_RATIO_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    !divTick |=> $stable(ratio)); // R7
  AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    divTick |=> (cnt == '0)); // R8
  AST_RATIO_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    ratio != '0); // R6

endmodule

// File: rtl/divbank_top.sv
`timescale 1ns/1ps
module divbank_top
  import divbank_pkg::*;
#(
  parameter int NUM_CH        = 4,
  parameter int DATA_W        = 32,
  parameter int DEFAULT_RATIO = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] divClk,
  output logic [NUM_CH-1:0] divTick
);

  chanStrobe_t stb [NUM_CH];

  divbank_ctrl #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .regSel (regSel),
    .wrData (wrData),
    .rdData (rdData),
    .stb    (stb)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    divbank_chan #(
      .DEFAULT_RATIO (DEFAULT_RATIO)
    ) chan_i (
      .clk     (clk),
      .rstN    (rstN),
      .stb     (stb[g]),
      .divClk  (divClk[g]),
      .divTick (divTick[g])
    );
  end

endmodule

// File: tb/divbank_top_tb_top.sv
`timescale 1ns/1ps
module divbank_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  divClk;
  logic [3:0]  divTick;

  int total = 0;
  int bad = 0;
  logic [31:0] shadow = '0;

  // {channel[1:0], code[5:0], expected ratio[5:0], expected error flag}
  localparam logic [14:0] VEC [NVEC] = '{
    {2'd0, 6'd1,  6'd2,  1'b0},
    {2'd0, 6'd2,  6'd1,  1'b0},
    {2'd0, 6'd5,  6'd6,  1'b0},
    {2'd0, 6'd6,  6'd5,  1'b0},
    {2'd0, 6'd9,  6'd10, 1'b0},
    {2'd0, 6'd10, 6'd9,  1'b0},
    {2'd0, 6'd0,  6'd9,  1'b1},
    {2'd0, 6'd11, 6'd9,  1'b1},
    {2'd1, 6'd63, 6'd63, 1'b0},
    {2'd1, 6'd1,  6'd1,  1'b0},
    {2'd1, 6'd0,  6'd1,  1'b1},
    {2'd1, 6'd7,  6'd7,  1'b1},
    {2'd2, 6'd2,  6'd2,  1'b0},
    {2'd3, 6'd3,  6'd3,  1'b0}
  };

  divbank_top dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .regSel  (regSel),
    .wrData  (wrData),
    .rdData  (rdData),
    .divClk  (divClk),
    .divTick (divTick)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic sel, input logic [31:0] data);
    @(negedge clk);
    regSel = sel;
    wrData = data;
    wrEn   = 1'b1;
    @(negedge clk);
    wrEn   = 1'b0;
  endtask

  task automatic readReg(input logic sel, output logic [31:0] data);
    @(negedge clk);
    regSel = sel;
    #1;
    data = rdData;
  endtask

  task automatic loadCode(input int ch, input logic [5:0] code);
    int lsb;
    lsb = 1 + 7 * ch;
    shadow = shadow & ~(32'h7F << lsb);
    shadow = shadow | (32'(code) << lsb);
    writeReg(1'b0, shadow);
    writeReg(1'b0, shadow | (32'h1 << (lsb + 6)));
    repeat (25) @(negedge clk);
    writeReg(1'b0, shadow);
  endtask

  task automatic measure(input int ch, output int per, output int hi);
    int guard;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!divTick[ch] && guard < 200);
    per = 0;
    hi  = 0;
    do begin
      @(negedge clk);
      per++;
      hi += int'(divClk[ch]);
    end while (!divTick[ch] && per < 200);
  endtask

  initial begin
    logic [31:0] rd;
    int per;
    int hi;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2: reset state of both words and of every channel
    readReg(1'b0, rd);
    check(rd == 32'h0, "R2 word0 reset", int'(rd), 0);
    readReg(1'b1, rd);
    check(rd == 32'h0, "R2 word1 reset", int'(rd), 0);
    for (int c = 0; c < 4; c++) begin
      measure(c, per, hi);
      check(per == 4, "R2 reset period", per, 4);
      check(hi == 2, "R8 reset high phase", hi, 2);
    end

    // R3: a load while the release bit is low is ignored, also after release
    loadCode(2, 6'd9);
    repeat (20) @(negedge clk);
    measure(2, per, hi);
    check(per == 4, "R3 load ignored while held", per, 4);
    writeReg(1'b1, 32'h400);
    repeat (20) @(negedge clk);
    measure(2, per, hi);
    check(per == 4, "R3 no late apply after release", per, 4);
    readReg(1'b1, rd);
    check(rd == 32'h400, "R1 word1 release readback", int'(rd), 32'h400);
    readReg(1'b0, rd);
    check(rd == shadow, "R1 word0 readback", int'(rd), int'(shadow));

    // Vector walk: R4 table channel, R5 direct channels, R6 invalid codes
    for (int v = 0; v < NVEC; v++) begin
      int ch;
      int expR;
      logic [5:0] code;
      logic expE;
      string tag;
      ch   = int'(VEC[v][14:13]);
      code = VEC[v][12:7];
      expR = int'(VEC[v][6:1]);
      expE = VEC[v][0];
      tag  = (ch == 0) ? "R4" : "R5";
      loadCode(ch, code);
      repeat (140) @(negedge clk);
      measure(ch, per, hi);
      check(per == expR, {tag, " period (R6 when invalid)"}, per, expR);
      if (expR > 1) begin
        check(hi == expR / 2, "R8 high phase", hi, expR / 2);
      end else begin
        @(posedge clk);
        #1;
        check(divClk[ch] == 1'b1, "R9 pass-through high", int'(divClk[ch]), 1);
        @(negedge clk);
        #1;
        check(divClk[ch] == 1'b0, "R9 pass-through low", int'(divClk[ch]), 0);
        check(divTick[ch] == 1'b1, "R9 tick held high", int'(divTick[ch]), 1);
      end
      readReg(1'b1, rd);
      check(rd[ch] == expE, "R6 error flag", int'(rd[ch]), int'(expE));
      readReg(1'b0, rd);
      check(rd[1 + 7 * ch +: 6] == code, "R1 code readback",
            int'(rd[1 + 7 * ch +: 6]), int'(code));
    end

    // R7: large step 63 -> 2 shows only whole periods of either ratio
    loadCode(1, 6'd63);
    repeat (140) @(negedge clk);
    measure(1, per, hi);
    check(per == 63, "R7 setup period", per, 63);
    loadCode(1, 6'd2);
    for (int k = 0; k < 4; k++) begin
      measure(1, per, hi);
      check(per == 63 || per == 2, "R7 no shortened period", per, 2);
    end
    check(per == 2, "R7 new ratio applied", per, 2);

    // R6: flags of untouched channels stay clear, set ones stay set
    readReg(1'b1, rd);
    check(rd[3:0] == 4'b0011, "R6 sticky flags", int'(rd[3:0]), 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule